// File: doc/BRIEF.md
# Frame Width Downsizer with Status Trailer

This block sits between a 64-bit receive path and a 32-bit processor-side AXI4-Stream port. It takes one wide word at a time over a valid/ready handshake and emits it as two narrow beats, most significant half first. Once the last word of a frame has gone out, it appends a single 32-bit status beat. That beat reports whether the frame ended good or bad, and it is the only beat of the frame that carries TLAST.

On the input side, the block accepts a new word only when it holds nothing. The source is therefore held off for as long as the halves of the current word, or a pending trailer, are still waiting to go out.

On the output side, back-pressure is standard AXI4-Stream. While TVALID is high and TREADY is low, TDATA, TKEEP and TLAST stay frozen and no internal state moves. A beat is consumed only on a cycle where both TVALID and TREADY are high.

Top module: `frame_downsizer`

## Requirements
- R1: While the synchronous active-high reset is high, and in the first cycle after it falls, `m_tvalid` is 0 and `in_ready` is 1.
- R2: The first output beat for each accepted word carries `in_data[63:32]`. For a word that is not the last of its frame, TKEEP is 4'hF.
- R3: The beat after the upper half carries `in_data[31:0]` of the same word.
- R4: After a word is accepted, `in_ready` is 0 until every beat from that word, and any trailer that follows it, has been taken.
- R5: After the last data beat of a frame, exactly one trailer beat follows. Its TDATA has bit 0 set to the good flag and bit 1 set to the bad flag, with every other bit 0. Its TKEEP is 4'hF and its TLAST is 1.
- R6: TLAST is 0 on every data beat.
- R7: On the last word, `in_keep[7:4]` becomes TKEEP of the upper beat and `in_keep[3:0]` becomes TKEEP of the lower beat. On any other word, `in_keep` is ignored and TKEEP is 4'hF.
- R8: When the last word has `in_keep[3:0]` equal to 0, its lower beat is skipped and the trailer follows the upper beat directly.
- R9: While `m_tvalid` is 1 and `m_tready` is 0, TDATA, TKEEP and TLAST hold their values and TVALID stays 1 into the next cycle.
- R10: `in_good` and `in_bad` are sampled only with the last word of a frame. Their values on earlier words have no effect on the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 64 | Input word, upper half goes out first |
| in_keep | input | 8 | Byte-valid mask, used only on the last word |
| in_last | input | 1 | Marks the last word of a frame |
| in_good | input | 1 | Frame ended good, taken with the last word |
| in_bad | input | 1 | Frame ended bad, taken with the last word |
| m_tdata | output | 32 | Output stream data |
| m_tkeep | output | 4 | Output stream byte enables |
| m_tlast | output | 1 | Set on the trailer beat only |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |

## Verification
If the phase register is wrong, the effect reaches the ports within one beat. Halves come out swapped or repeated, a lower beat appears where it should be skipped, or the trailer is missing or doubled. The scoreboard catches each of these on the very next beat that is taken.

If the captured flags or keep mask are wrong, the trailer value or a TKEEP field is wrong. This shows at the end of the frame in which the fault occurred. A state that advances during a stall changes the frozen beat one cycle later. A ready signal raised too early lets a second word overwrite the held one, and half a word goes missing.

// File: rtl/dnz_pkg.sv
package dnz_pkg;
  // Output phase of the held word.
  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,
    PH_HIGH  = 2'd1,
    PH_LOW   = 2'd2,
    PH_TRAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/dnz_ctrl.sv
module dnz_ctrl
  import dnz_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic [IN_W/8-1:0] in_keep,
  input  logic              in_last,
  input  logic              in_good,
  input  logic              in_bad,
  input  logic              beat_taken,
  output phase_t            phase_o,
  output logic [IN_W-1:0]   word_o,
  output logic [IN_W/8-1:0] keep_o,
  output logic              good_o,
  output logic              bad_o
);
  localparam int IKW = IN_W / 8;
  localparam int OKW = IKW / 2;

  phase_t            phase_q;
  logic [IN_W-1:0]   word_q;
  logic [IKW-1:0]    keep_q;
  logic              last_q;
  logic              good_q;
  logic              bad_q;
  logic              take;
  logic              low_empty;

  assign in_ready  = (phase_q == PH_EMPTY);
  assign take      = in_valid && in_ready;
  assign low_empty = last_q && (keep_q[OKW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_EMPTY;
      word_q  <= '0;
      keep_q  <= '0;
      last_q  <= 1'b0;
      good_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_EMPTY: if (take) begin
          word_q  <= in_data;
          keep_q  <= in_last ? in_keep : '1;
          last_q  <= in_last;
          good_q  <= in_last && in_good;
          bad_q   <= in_last && in_bad;
          phase_q <= PH_HIGH;
        end
        PH_HIGH: if (beat_taken) begin
          phase_q <= low_empty ? PH_TRAIL : PH_LOW;
        end
        PH_LOW: if (beat_taken) begin
          phase_q <= last_q ? PH_TRAIL : PH_EMPTY;
        end
        PH_TRAIL: if (beat_taken) begin
          phase_q <= PH_EMPTY;
        end
        default: phase_q <= PH_EMPTY;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign word_o  = word_q;
  assign keep_o  = keep_q;
  assign good_o  = good_q;
  assign bad_o   = bad_q;

  // R4
  no_second_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready);
endmodule

// File: rtl/dnz_beat_sel.sv
module dnz_beat_sel
  import dnz_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  phase_t              phase,
  input  logic [IN_W-1:0]     word,
  input  logic [IN_W/8-1:0]   keep,
  input  logic                good,
  input  logic                bad,
  output logic [IN_W/2-1:0]   tdata,
  output logic [IN_W/16-1:0]  tkeep,
  output logic                tlast,
  output logic                tvalid
);
  localparam int OUT_W = IN_W / 2;
  localparam int OKW   = OUT_W / 8;

  always_comb begin
    tdata  = '0;
    tkeep  = '0;
    tlast  = 1'b0;
    tvalid = 1'b0;
    case (phase)
      PH_HIGH: begin
        tdata  = word[IN_W-1:OUT_W];
        tkeep  = keep[2*OKW-1:OKW];
        tvalid = 1'b1;
      end
      PH_LOW: begin
        tdata  = word[OUT_W-1:0];
        tkeep  = keep[OKW-1:0];
        tvalid = 1'b1;
      end
      PH_TRAIL: begin
        tdata[0] = good;
        tdata[1] = bad;
        tkeep    = '1;
        tlast    = 1'b1;
        tvalid   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frame_downsizer.sv
module frame_downsizer
  import dnz_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic [IN_W/8-1:0] in_keep,
  input  logic              in_last,
  input  logic              in_good,
  input  logic              in_bad,
  output logic [IN_W/2-1:0] m_tdata,
  output logic [IN_W/16-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  localparam int OUT_W = IN_W / 2;
  localparam int IKW   = IN_W / 8;

  phase_t          phase;
  logic [IN_W-1:0] word;
  logic [IKW-1:0]  keep;
  logic            good;
  logic            bad;
  logic            beat_taken;

  assign beat_taken = m_tvalid && m_tready;

  dnz_ctrl #(.IN_W(IN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_keep    (in_keep),
    .in_last    (in_last),
    .in_good    (in_good),
    .in_bad     (in_bad),
    .beat_taken (beat_taken),
    .phase_o    (phase),
    .word_o     (word),
    .keep_o     (keep),
    .good_o     (good),
    .bad_o      (bad)
  );

  dnz_beat_sel #(.IN_W(IN_W)) u_sel (
    .phase  (phase),
    .word   (word),
    .keep   (keep),
    .good   (good),
    .bad    (bad),
    .tdata  (m_tdata),
    .tkeep  (m_tkeep),
    .tlast  (m_tlast),
    .tvalid (m_tvalid)
  );

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                  && $stable(m_tkeep) && $stable(m_tlast)));

  // R2
  upper_first_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (m_tvalid && !m_tlast
                                 && m_tdata == $past(in_data[IN_W-1:OUT_W])));

  // R5
  trailer_form_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tlast) |-> (m_tkeep == '1 && m_tdata[OUT_W-1:2] == '0));

  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !m_tvalid);
endmodule

// File: tb/frame_downsizer_bench.sv
module frame_downsizer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [7:0]  in_keep = '0;
  logic        in_last = 1'b0;
  logic        in_good = 1'b0;
  logic        in_bad = 1'b0;
  logic [31:0] m_tdata;
  logic [3:0]  m_tkeep;
  logic        m_tlast;
  logic        m_tvalid;
  logic        m_tready = 1'b0;

  int checks = 0;
  int fails = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  typedef struct packed {
    logic [31:0] d;
    logic [3:0]  k;
    logic        l;
  } beat_t;

  beat_t exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  frame_downsizer u_frame_downsizer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
    .in_good(in_good), .in_bad(in_bad), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
    .m_tready(m_tready)
  );

  task automatic push(input logic [31:0] d, input logic [3:0] k, input logic l,
                      input string tag);
    beat_t b;
    b.d = d; b.k = k; b.l = l;
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // Driver: one wide word, expected beats pushed to the scoreboard.
  task automatic send_word(input logic [63:0] d, input logic [7:0] k,
                           input logic lst, input logic g, input logic b);
    if (!lst) begin
      push(d[63:32], 4'hF, 1'b0, "R2");
      push(d[31:0], 4'hF, 1'b0, "R3");
    end else begin
      push(d[63:32], k[7:4], 1'b0, "R7");
      if (k[3:0] != 4'h0) push(d[31:0], k[3:0], 1'b0, "R3");
      push({30'd0, b, g}, 4'hF, 1'b1, "R5");
    end
    in_valid = 1'b1; in_data = d; in_keep = k;
    in_last = lst; in_good = g; in_bad = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R4 in_ready after accept: actual %b expected 0", in_ready);
    end
  endtask

  // Monitor: picks TREADY, then compares taken beats and stall stability.
  beat_t prev;
  bit    stalled = 0;
  always begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: m_tready = 1'b1;
      1: m_tready = ~m_tready;
      default: m_tready = lfsr[0];
    endcase
    #1;
    if (!rst && m_tvalid) begin
      if (stalled) begin
        checks++;
        if ({m_tdata, m_tkeep, m_tlast} !== prev) begin
          fails++;
          $display("FAIL R9 stalled beat changed: actual %h expected %h",
                   {m_tdata, m_tkeep, m_tlast}, prev);
        end
      end
      if (m_tready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R5 unexpected beat: actual %h expected none",
                   {m_tdata, m_tkeep, m_tlast});
        end else begin
          beat_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({m_tdata, m_tkeep, m_tlast} !== e) begin
            fails++;
            $display("FAIL %s R6 beat: actual d=%h k=%h l=%b expected d=%h k=%h l=%b",
                     t, m_tdata, m_tkeep, m_tlast, e.d, e.k, e.l);
          end
        end
      end
      stalled = !m_tready;
      prev = {m_tdata, m_tkeep, m_tlast};
    end else begin
      stalled = 0;
    end
  end

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || m_tvalid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing beats: actual %0d left expected 0", exp_q.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (m_tvalid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset: actual v=%b r=%b expected v=0 r=1", m_tvalid, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (m_tvalid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 after reset: actual v=%b r=%b expected v=0 r=1", m_tvalid, in_ready);
    end

    // Single-word frame, full keep, good.
    send_word(64'h1122_3344_5566_7788, 8'hFF, 1'b1, 1'b1, 1'b0);
    drain();
    // R8: three words, last lower half empty, bad.
    send_word(64'hA0A1_A2A3_A4A5_A6A7, 8'h00, 1'b0, 1'b0, 1'b0);
    send_word(64'hB0B1_B2B3_B4B5_B6B7, 8'h00, 1'b0, 1'b0, 1'b0);
    send_word(64'hC0C1_C2C3_C4C5_C6C7, 8'hF0, 1'b1, 1'b0, 1'b1);
    drain();
    // R10: flags on a non-last word ignored; R7 partial keep.
    send_word(64'hDEAD_BEEF_0BAD_F00D, 8'h3C, 1'b0, 1'b1, 1'b1);
    send_word(64'h0102_0304_0506_0708, 8'hFC, 1'b1, 1'b0, 1'b1);
    drain();
    // R9: alternating and pseudo-random back-pressure.
    for (int m = 1; m <= 2; m++) begin
      ready_mode = m;
      for (int f = 0; f < 6; f++) begin
        for (int w = 0; w < f % 3; w++)
          send_word({8'(f), 8'(w), 16'h5A5A, 8'(m), 24'h0F0F0F}, 8'h00, 1'b0, 1'b1, 1'b0);
        send_word({32'hFACE_0000 | 32'(f), 32'hC0DE_0000 | 32'(m)},
                  (f % 2 == 0) ? 8'hF8 : 8'hE0, 1'b1, f[0], ~f[0]);
      end
      drain();
    end
    ready_mode = 0;
    // Both flags set together.
    send_word(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, 1'b1, 1'b1);
    drain();
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || m_tvalid !== 1'b0) begin
      fails++;
      $display("FAIL R4 idle at end: actual r=%b v=%b expected r=1 v=0", in_ready, m_tvalid);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule